// File: doc/BRIEF.md
# Double-Buffered DAC Serial Command Interface

This block is the digital front end of a 12-bit voltage DAC. It is a three-wire serial slave with an active-low select, a serial clock and a data line. A host selects the block, clocks in one 16-bit frame and releases the select. The frame holds a 3-bit command, 12 data bits and a trailing sub-bit. The command acts when the select is released, and not when the last bit arrives.

The data path has two registers. A staging register holds incoming data. A second register drives the converter. Depending on the command, a frame does one of the following:
- writes only the staging register;
- writes both registers together;
- copies staging into the converter register;
- does nothing;
- puts the output into a power-down state.

Leaving power-down recalls the code that was held before it. A frame with the wrong bit count is discarded and raises a sticky error flag.

All three serial pins are sampled by the system clock, which must run at least four times faster than the serial clock. Edges are found after synchronization.

Top module: `dac_cmd_slave`

## Requirements
- R1: While reset is asserted and right after it, `dac_code` is 0, `shutdown` is 0 and `frame_err` is 0. The staging register is also 0.
- R2: A frame is 16 bits, taken from `din` on rising `sclk` while `cs_n` is low, most significant bit first, in this order: command bits c2 c1 c0, then data d11 down to d0, then the sub-bit. Rising `sclk` edges while `cs_n` is high shift nothing.
- R3: No output changes before the rising edge of `cs_n`, even after all 16 bits have been received. Results appear a few system clocks after `cs_n` rises.
- R4: A frame sent as two 8-bit bursts, with `cs_n` held low during the pause, acts exactly as a single 16-bit burst.
- R5: Commands 000 and 100 (c1 c0 = 00) are no-operations. They leave both registers and `shutdown` unchanged.
- R6: Commands 001 and 101 (c1 c0 = 01) write the data into both the staging register and `dac_code`, and clear `shutdown`.
- R7: Commands 010 and 110 (c1 c0 = 10) write the data into the staging register only. `dac_code` stays unchanged.
- R8: Command 011 copies the staging register into `dac_code` and clears `shutdown`. Its data bits are ignored.
- R9: Command 111 sets `shutdown` and changes neither register, so `dac_code` keeps its value.
- R10: If `cs_n` rises after any count of `sclk` rising edges other than 16, no command runs and `frame_err` becomes 1. It stays 1 until a correctly sized frame arrives, which clears it.
- R11: The value of the sub-bit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select; its rising edge executes the frame |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| din | input | 1 | Serial data, most significant bit first |
| dac_code | output | 12 | Contents of the converter register |
| shutdown | output | 1 | High while the output is powered down |
| frame_err | output | 1 | Sticky flag for a mis-sized frame |

## Verification
The bench builds the block with its default parameters: 12 data bits and a two-stage synchronizer. This gives the full 16-bit frame and a serial clock at one eighth of the system clock. With these values, every command code (including both values of the don't-care bit), both power-down exits, split bursts and short or long frames can all be driven within a short run. It also lets the bench sample outputs in the gap between the last serial bit and the rise of `cs_n`, which shows that nothing runs early.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_LOAD_UPD,
    OP_LOAD_ONLY,
    OP_RECALL,
    OP_SHUTDOWN
  } op_e;

  // Total serial frame length for a given data width: command, data, sub-bit.
  function automatic int frame_len(input int data_w);
    return CMD_W + data_w + 1;
  endfunction

  // The top command bit matters only when the lower two are both set.
  function automatic op_e decode_cmd(input logic [CMD_W-1:0] c);
    op_e op;
    unique case (c[1:0])
      2'b00:   op = OP_NOP;
      2'b01:   op = OP_LOAD_UPD;
      2'b10:   op = OP_LOAD_ONLY;
      default: op = c[2] ? OP_SHUTDOWN : OP_RECALL;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= RST_VAL;
          else        pipe[g] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= RST_VAL;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter #(
  parameter int FRAME_LEN = 16,
  localparam int CNT_W    = $clog2(FRAME_LEN + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_idle,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [FRAME_LEN-1:0] frame,
  output logic [CNT_W-1:0]     bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_LEN + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame   <= '0;
      bit_cnt <= '0;
    end else if (sel_idle) begin
      bit_cnt <= '0;
    end else if (shift_en) begin
      frame <= {frame[FRAME_LEN-2:0], bit_in};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dcs_regfile.sv
module dcs_regfile
  import dcs_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              run_bad,
  input  op_e               op,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] stage_word,
  output logic [DATA_W-1:0] out_word,
  output logic              pwr_down,
  output logic              err_flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_word <= '0;
      out_word   <= '0;
      pwr_down   <= 1'b0;
      err_flag   <= 1'b0;
    end else if (run_bad) begin
      err_flag <= 1'b1;
    end else if (run_ok) begin
      err_flag <= 1'b0;
      case (op)
        OP_LOAD_UPD: begin
          stage_word <= data;
          out_word   <= data;
          pwr_down   <= 1'b0;
        end
        OP_LOAD_ONLY: stage_word <= data;
        OP_RECALL: begin
          out_word <= stage_word;
          pwr_down <= 1'b0;
        end
        OP_SHUTDOWN: pwr_down <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dac_cmd_slave.sv
module dac_cmd_slave
  import dcs_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic [DATA_W-1:0] dac_code,
  output logic              shutdown,
  output logic              frame_err
);

  localparam int FRAME_LEN = frame_len(DATA_W);
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);

  // synchronized pins: [2]=cs_n, [1]=sclk, [0]=din
  logic [2:0] pins_s;
  logic       cs_q, sclk_q;

  dcs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({cs_n, sclk, din}),
    .sync_out(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= pins_s[2];
      sclk_q <= pins_s[1];
    end
  end

  // named events, brought out for the checker
  logic cs_rise_evt, sclk_rise_evt, exec_ok, exec_bad;
  assign cs_rise_evt   = pins_s[2] & ~cs_q;
  assign sclk_rise_evt = pins_s[1] & ~sclk_q & ~pins_s[2];

  logic [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0]     bit_cnt;

  dcs_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_idle(pins_s[2]),
    .shift_en(sclk_rise_evt),
    .bit_in(pins_s[0]),
    .frame(frame),
    .bit_cnt(bit_cnt)
  );

  assign exec_ok  = cs_rise_evt & (bit_cnt == CNT_W'(FRAME_LEN));
  assign exec_bad = cs_rise_evt & (bit_cnt != CNT_W'(FRAME_LEN));

  logic [CMD_W-1:0]  cmd_field;
  logic [DATA_W-1:0] data_field;
  op_e               op;
  logic [DATA_W-1:0] in_word;

  assign cmd_field  = frame[FRAME_LEN-1 -: CMD_W];
  assign data_field = frame[FRAME_LEN-1-CMD_W -: DATA_W];
  assign op         = decode_cmd(cmd_field);

  dcs_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .run_ok(exec_ok), .run_bad(exec_bad),
    .op(op), .data(data_field),
    .stage_word(in_word),
    .out_word(dac_code),
    .pwr_down(shutdown),
    .err_flag(frame_err)
  );

endmodule

// File: rtl/dcs_chk.sv
module dcs_chk
  import dcs_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise_evt,
  input logic              exec_ok,
  input logic              exec_bad,
  input op_e               op,
  input logic [DATA_W-1:0] data_field,
  input logic [DATA_W-1:0] in_word,
  input logic [DATA_W-1:0] dac_code,
  input logic              shutdown,
  input logic              frame_err
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (dac_code == '0 && !shutdown && !frame_err && in_word == '0));

  // R3
  no_early_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise_evt |=> ($stable(dac_code) && $stable(shutdown) && $stable(frame_err)));

  // R5
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_NOP) |=> ($stable(dac_code) && $stable(shutdown) && $stable(in_word)));

  // R6
  load_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_LOAD_UPD) |=> (dac_code == $past(data_field) && in_word == $past(data_field) && !shutdown));

  // R7
  load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_LOAD_ONLY) |=> ($stable(dac_code) && in_word == $past(data_field)));

  // R8
  recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_RECALL) |=> (dac_code == $past(in_word) && !shutdown));

  // R9
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_ok && op == OP_SHUTDOWN) |=> (shutdown && $stable(dac_code) && $stable(in_word)));

  // R10
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_bad |=> (frame_err && $stable(dac_code) && $stable(shutdown) && $stable(in_word)));

  // R10
  good_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ok |=> !frame_err);

endmodule

bind dac_cmd_slave dcs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_rise_evt(cs_rise_evt), .exec_ok(exec_ok), .exec_bad(exec_bad),
  .op(op), .data_field(data_field), .in_word(in_word),
  .dac_code(dac_code), .shutdown(shutdown), .frame_err(frame_err)
);

// File: tb/tb_dac_cmd_slave.sv
`timescale 1ns/1ps
module tb_dac_cmd_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] dac_code;
  logic        shutdown, frame_err;

  always #2.5 clk = ~clk;

  dac_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dac_code(dac_code), .shutdown(shutdown), .frame_err(frame_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [11:0] m_in = '0, m_dac = '0;
  logic        m_sd = 1'b0, m_err = 1'b0;

  typedef struct {
    logic [11:0] dac;
    logic        sd;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  event frame_done;

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual dac=%h sd=%b err=%b expected dac=%h sd=%b err=%b",
               tag, act[13:2], act[1], act[0], exp[13:2], exp[1], exp[0]);
    end
  endtask

  // model of the command set, written from the requirements
  task automatic model(input logic [2:0] c, input logic [11:0] d, input int nbits);
    if (nbits != 16) begin
      m_err = 1'b1;                          // R10
    end else begin
      m_err = 1'b0;
      if (c[1:0] == 2'b01) begin m_in = d; m_dac = d; m_sd = 1'b0; end  // R6
      else if (c[1:0] == 2'b10) m_in = d;                                // R7
      else if (c == 3'b011) begin m_dac = m_in; m_sd = 1'b0; end         // R8
      else if (c == 3'b111) m_sd = 1'b1;                                 // R9
    end
  endtask

  task automatic put_bit(input logic b);
    din = b;
    #20 sclk = 1'b1;
    #20 sclk = 1'b0;
  endtask

  // driver: sends a frame, checks nothing ran early, pushes expectation
  task automatic send(input string tag, input logic [2:0] c, input logic [11:0] d,
                      input logic sub, input int nbits, input bit split);
    logic [15:0] w;
    w = {c, d, sub};
    cs_n = 1'b0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      put_bit(i < 16 ? w[15-i] : 1'b0);
      if (split && i == 7) #200;             // R4 pause, select still low
    end
    #40;
    // R3: all bits in, select still low, outputs must be unchanged
    check({tag, " R3 before cs rise"}, {dac_code, shutdown, frame_err}, {m_dac, m_sd, m_err});
    cs_n = 1'b1;
    model(c, d, nbits);
    sb_q.push_back('{m_dac, m_sd, m_err, tag});
    #100;
    -> frame_done;
    #20;
  endtask

  // monitor
  initial begin
    forever begin
      @(frame_done);
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual dac=%h expected an entry", dac_code);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {dac_code, shutdown, frame_err}, {e.dac, e.sd, e.err});
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    check("R1 during reset", {dac_code, shutdown, frame_err}, 14'b0);
    #20 rst_n = 1'b1;
    #40;
    check("R1 after reset", {dac_code, shutdown, frame_err}, 14'b0);

    send("R6 load+update c2=0", 3'b001, 12'hA5C, 1'b0, 16, 0);
    send("R6 load+update c2=1", 3'b101, 12'h3F0, 1'b0, 16, 0);
    send("R7 load only", 3'b010, 12'h123, 1'b0, 16, 0);
    send("R7 load only c2=1", 3'b110, 12'h124, 1'b0, 16, 0);
    send("R8 copy staging", 3'b011, 12'hFFF, 1'b0, 16, 0);
    send("R9 shutdown", 3'b111, 12'h000, 1'b0, 16, 0);
    send("R5 nop c2=1 in shutdown", 3'b100, 12'hFFF, 1'b0, 16, 0);
    send("R5 nop c2=0", 3'b000, 12'h777, 1'b0, 16, 0);
    send("R8 recall exits shutdown", 3'b011, 12'h000, 1'b0, 16, 0);
    send("R9 shutdown again", 3'b111, 12'hABC, 1'b0, 16, 0);
    send("R6 load exits shutdown", 3'b001, 12'h0F0, 1'b0, 16, 0);
    send("R10 short frame", 3'b001, 12'hDEF, 1'b0, 10, 0);
    send("R10 long frame sticky", 3'b001, 12'h111, 1'b0, 20, 0);
    send("R10 empty frame sticky", 3'b001, 12'h222, 1'b0, 0, 0);
    send("R10 valid nop clears", 3'b000, 12'h333, 1'b0, 16, 0);
    send("R4 split bursts", 3'b001, 12'h801, 1'b0, 16, 1);
    send("R11 sub-bit set", 3'b001, 12'h555, 1'b1, 16, 0);
    send("R11 sub-bit on staging", 3'b010, 12'h666, 1'b1, 16, 0);
    send("R11 recall after sub-bit", 3'b011, 12'h000, 1'b1, 16, 0);

    // R2: serial clock pulses while deselected must shift nothing
    din = 1'b1;
    for (int k = 0; k < 5; k++) begin
      #20 sclk = 1'b1;
      #20 sclk = 1'b0;
    end
    #40;
    send("R2 clocks while deselected", 3'b001, 12'hAAA, 1'b0, 16, 0);
    send("R2 bit order", 3'b101, 12'h001, 1'b0, 16, 0);

    #100;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule